// File: doc/BRIEF.md
# Clock Frequency Meter

This block measures a slow or unknown clock, for example an on-chip ring oscillator, against the reference clock that runs the rest of the block. Software programs a window length counted in edges of the measured clock and sets the meter enable. It also sets a separate free-run enable, which gates the measured-clock counter. While both enables are high, the block counts reference cycles until the measured clock has produced the programmed number of edges. It then stores that reference count as the result and raises a sticky valid flag. A faster measured clock gives a smaller result. A result of zero means the measurement failed.

The measured-clock edge count is kept as a Gray-coded counter in the measured domain. It crosses into the reference domain through a two-flop synchroniser. At the start of a run the reference side takes a snapshot of that count, so the counter never has to be reset across domains. The measured clock must run slower than the reference clock.

Software polls the valid flag and reads the result. It then clears the meter enable and the free-run enable. Clearing either enable drops the valid flag and the internal counters. The stored result stays readable until the next run starts.

Top module: `freq_meter`

## Requirements
- R1: Address 0 is the control register. Bits 23:0 hold the window length in measured-clock edges and bit 24 holds the meter enable. Both read back as written, and bits 31:25 read as zero.
- R2: Address 1 is the status register. Bit 8 is the free-run enable, which is writable. Bit 0 is the valid flag, which is read-only: writing it has no effect. All other bits read as zero.
- R3: A run begins only while the meter enable and the free-run enable are both high. With the free-run enable low, valid stays 0 and the result register keeps its previous value.
- R4: Address 2 returns the result, zero-extended to 32 bits. The result equals k-1, where k is the number of reference rising edges from the edge that stores the starting write up to and including the edge that sets valid.
- R5: Valid sets once the synchronised measured-clock edge count has advanced by at least the window since the run began. A slower measured clock therefore gives a larger result. A window of 0 completes with a result of 1.
- R6: While both enables stay high, valid stays set and the result does not change.
- R7: When either enable is cleared, valid reads 0 from the second reference edge after the write onward, and the stored result is kept.
- R8: On the first reference edge after a run begins, the result register clears to zero. It stays zero until the run completes.
- R9: The reference counter saturates at its all-ones value and does not wrap. A run that completes with the counter saturated reports a result of 0 with valid set.
- R10: After reset, the control, status and result registers all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, held for several measured-clock periods |
| meas_clk | input | 1 | Clock under measurement, slower than clk |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 result |
| reg_wr | input | 1 | Write strobe, sampled on the clk rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
A wrong reference count or a wrong start-of-run snapshot shows up in the result on the first completed run. The result is checked exactly against the number of cycles the bench counts between starting the run and seeing valid. Faults in the crossing or in the window compare move the cycle in which valid rises, so the bench checks that cycle against the measured-to-reference period ratio. It also checks that a faster clock gives a smaller count. The sticky-flag, clear-on-stop and clear-on-start rules are compared on every reference cycle, so a fault in any of them is reported within one or two cycles of the write that exposes it.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int WIN_W  = 24;
    localparam int CNT_W  = WIN_W + 1;
    localparam int FR_BIT = 8;
    localparam int VAL_BIT = 0;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RES  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DONE = 2'd2
    } meter_st_e;

    typedef struct packed {
        logic             en;
        logic [WIN_W-1:0] win;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fm_meas_cnt.sv
module fm_meas_cnt
    import fm_pkg::*;
(
    input  logic             meas_clk,
    input  logic             rst,
    input  logic             gate_async,
    output logic [CNT_W-1:0] gray_q
);
    logic             gate_m;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_next;

    fm_sync #(.W(1)) u_gate_sync (
        .clk (meas_clk),
        .rst (rst),
        .d   (gate_async),
        .q   (gate_m)
    );

    assign bin_next = bin_q + 1'b1;

    always_ff @(posedge meas_clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (gate_m) begin
            bin_q  <= bin_next;
            gray_q <= bin2gray(bin_next);
        end
    end
endmodule

// File: rtl/fm_regs.sv
module fm_regs
    import fm_pkg::*;
#(
    parameter int REF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              valid,
    input  logic [REF_W-1:0]  result,
    output logic              run,
    output logic              fr_en,
    output logic [WIN_W-1:0]  window
);
    ctrl_t ctrl_q;
    logic  fr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            fr_q   <= 1'b0;
        end else if (wr) begin
            if (addr == ADDR_CTRL) begin
                ctrl_q <= ctrl_t'(wdata[WIN_W:0]);
            end
            if (addr == ADDR_STAT) begin
                fr_q <= wdata[FR_BIT];
            end
        end
    end

    assign run    = ctrl_q.en & fr_q;
    assign fr_en  = fr_q;
    assign window = ctrl_q.win;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata[WIN_W:0] = ctrl_q;
            ADDR_STAT: begin
                rdata[FR_BIT]  = fr_q;
                rdata[VAL_BIT] = valid;
            end
            ADDR_RES:  rdata[REF_W-1:0] = result;
            default:   rdata = '0;
        endcase
    end

    // R1: a control write is visible on the next cycle
    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_CTRL) |=> (ctrl_q == ctrl_t'($past(wdata[WIN_W:0]))));
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
    import fm_pkg::*;
#(
    parameter int REF_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [WIN_W-1:0] window,
    input  logic [CNT_W-1:0] meas_gray,
    output logic             valid,
    output logic [REF_W-1:0] result
);
    localparam logic [REF_W-1:0] REF_MAX = {REF_W{1'b1}};

    meter_st_e        st;
    logic [REF_W-1:0] ref_cnt;
    logic [REF_W-1:0] ref_inc;
    logic [CNT_W-1:0] g_sync;
    logic [CNT_W-1:0] m_now;
    logic [CNT_W-1:0] m_base;
    logic [CNT_W-1:0] m_delta;
    logic             reached;

    fm_sync #(.W(CNT_W)) u_gray_sync (
        .clk (clk),
        .rst (rst),
        .d   (meas_gray),
        .q   (g_sync)
    );

    assign m_now   = gray2bin(g_sync);
    assign m_delta = m_now - m_base;
    assign reached = (m_delta >= {1'b0, window});
    assign ref_inc = (ref_cnt == REF_MAX) ? REF_MAX : ref_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ref_cnt <= '0;
            m_base  <= '0;
            valid   <= 1'b0;
            result  <= '0;
        end else if (!run) begin
            st      <= ST_IDLE;
            ref_cnt <= '0;
            valid   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    st      <= ST_MEAS;
                    ref_cnt <= '0;
                    m_base  <= m_now;
                    result  <= '0;
                end
                ST_MEAS: begin
                    ref_cnt <= ref_inc;
                    if (reached) begin
                        valid  <= 1'b1;
                        result <= (ref_inc == REF_MAX) ? '0 : ref_inc;
                        st     <= ST_DONE;
                    end
                end
                default: st <= ST_DONE;
            endcase
        end
    end

    // R7: stopping the run clears the flag
    assert_clear_on_stop_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> !valid);

    // R6: flag is sticky while the run continues
    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && run) |=> valid);

    // R6: result frozen while flagged
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && run) |=> $stable(result));

    // R9: reference counter never wraps
    assert_ref_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MEAS && run && ref_cnt == REF_MAX) |=> (ref_cnt == REF_MAX));

    // R3: no counting without a run
    assert_idle_no_count_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ref_cnt == '0 && st == ST_IDLE));

    // R8: result is zero while a run is still counting
    assert_zero_while_meas_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MEAS && !valid) |-> (result == '0));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fm_pkg::*;
#(
    parameter int REF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_clk,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic             run;
    logic             fr_en;
    logic [WIN_W-1:0] window;
    logic             valid;
    logic [REF_W-1:0] result;
    logic [CNT_W-1:0] meas_gray;

    fm_regs #(.REF_W(REF_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .valid  (valid),
        .result (result),
        .run    (run),
        .fr_en  (fr_en),
        .window (window)
    );

    fm_meas_cnt u_meas (
        .meas_clk   (meas_clk),
        .rst        (rst),
        .gate_async (fr_en),
        .gray_q     (meas_gray)
    );

    fm_ctrl #(.REF_W(REF_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .window    (window),
        .meas_gray (meas_gray),
        .valid     (valid),
        .result    (result)
    );
endmodule

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W_TB   = 12;
    localparam int SAT_VAL    = (1 << REF_W_TB) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        meas_clk = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    real meas_half = 18.5;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int  m_win = 0;
    bit  m_en = 0, m_fr = 0;
    bit  prev_run = 0;
    bit  measuring = 0, seen_valid = 0;
    int  n = 0, k_seen = 0;
    int  m_res = 0;
    bit  pend_wr = 0;
    int  pend_addr = 0;
    logic [31:0] pend_data = '0;

    freq_meter #(.REF_W(REF_W_TB)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .meas_clk  (meas_clk),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial forever #(meas_half) meas_clk = ~meas_clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        bit run;
        bit v;
        @(negedge clk);
        if (pend_wr) begin
            if (pend_addr == 0) begin
                m_win = int'(pend_data[23:0]);
                m_en  = pend_data[24];
            end else if (pend_addr == 1) begin
                m_fr = pend_data[8];
            end
            pend_wr = 0;
        end
        run = m_en && m_fr;
        if (run && !prev_run) begin
            measuring = 1; n = 0; seen_valid = 0;
        end else if (run) begin
            n++;
        end
        if (!run) measuring = 0;

        case (reg_addr)
            2'd0: chk(reg_rdata == {7'b0, m_en, m_win[23:0]}, "R1 control readback",
                      reg_rdata, {7'b0, m_en, m_win[23:0]});
            2'd1: begin
                v = reg_rdata[0];
                chk((reg_rdata & 32'hFFFF_FFFE) == (32'(m_fr) << 8), "R2 status bits",
                    reg_rdata & 32'hFFFF_FFFE, 32'(m_fr) << 8);
                if (!run && !prev_run) begin
                    chk(v == 1'b0, m_en ? "R3 no valid without both enables" : "R7 valid cleared",
                        v, 0);
                end else if (run && prev_run) begin
                    if (seen_valid) begin
                        chk(v == 1'b1, "R6 valid sticky", v, 1);
                    end else if (v) begin
                        seen_valid = 1;
                        k_seen = n;
                        m_res = ((k_seen - 1) >= SAT_VAL) ? 0 : (k_seen - 1);
                        begin
                            real r, lo, hi;
                            r  = (2.0 * meas_half) / CLK_PERIOD;
                            lo = (m_win - 1) * r - 4.0;
                            hi = (m_win + 4) * r + 6.0;
                            chk(k_seen >= lo && k_seen <= hi, "R5 completion cycle in window",
                                k_seen, longint'(m_win * r));
                        end
                    end
                end
            end
            2'd2: begin
                if (measuring && !seen_valid && n >= 1)
                    chk(reg_rdata == 32'd0, "R8 result cleared during run", reg_rdata, 0);
                else
                    chk(reg_rdata == 32'(m_res), "R4 result value", reg_rdata, m_res);
            end
            default: ;
        endcase
        prev_run = run;
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        reg_addr  = 2'(addr);
        reg_wdata = data;
        reg_wr    = 1'b1;
        pend_wr   = 1;
        pend_addr = addr;
        pend_data = data;
        step();
        reg_wr   = 1'b0;
        reg_addr = 2'd1;
    endtask

    task automatic idle(input int cycles, input int addr);
        reg_addr = 2'(addr);
        for (int i = 0; i < cycles; i++) step();
    endtask

    task automatic poll(input int limit);
        reg_addr = 2'd1;
        for (int i = 0; i < limit && !seen_valid; i++) step();
        chk(seen_valid == 1, "R5 measurement completes", seen_valid, 1);
    endtask

    task automatic read_result(output int val);
        reg_addr = 2'd2;
        step();
        val = int'(reg_rdata);
        reg_addr = 2'd1;
    endtask

    initial begin
        #(200000 * CLK_PERIOD);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int res_a, res_b, tmp;
        repeat (20) @(negedge clk);
        rst = 1'b0;

        // R10: reset values
        reg_addr = 2'd0; step(); chk(reg_rdata == 0, "R10 control after reset", reg_rdata, 0);
        reg_addr = 2'd1; step(); chk(reg_rdata == 0, "R10 status after reset", reg_rdata, 0);
        reg_addr = 2'd2; step(); chk(reg_rdata == 0, "R10 result after reset", reg_rdata, 0);

        // R1, R2: field positions, unused bits, read-only valid
        wr(0, 32'hFFFF_FFFF);
        idle(2, 0);
        wr(0, 32'h0000_0000);
        wr(1, 32'hFFFF_FFFF);
        idle(3, 1);
        chk(reg_rdata == 32'h0000_0100, "R2 write to valid ignored", reg_rdata, 32'h100);
        wr(1, 32'h0);
        idle(3, 1);

        // R3: meter enabled but free-run gate off
        meas_half = 18.5;
        wr(0, (32'd1 << 24) | 32'd50);
        idle(600, 1);
        idle(2, 2);
        chk(reg_rdata == 0, "R3 result untouched while gated", reg_rdata, 0);

        // R4/R5: open the gate, measure 50 edges of a 37 ns clock
        wr(1, 32'h100);
        poll(3000);
        read_result(res_a);
        chk(res_a == k_seen - 1, "R4 result equals counted cycles", res_a, k_seen - 1);
        idle(20, 1);                       // R6 sticky
        idle(5, 2);                        // R6 result stable

        // R7: stop by clearing meter enable
        wr(0, 32'd50);
        idle(4, 1);
        idle(3, 2);
        chk(reg_rdata == 32'(res_a), "R7 result kept after stop", reg_rdata, res_a);

        // R5: faster clock gives a smaller count
        meas_half = 11.5;
        idle(10, 1);
        wr(0, (32'd1 << 24) | 32'd50);
        poll(3000);
        read_result(res_b);
        chk(res_b < res_a && res_b > 0, "R5 faster clock smaller count", res_b, res_a);
        wr(1, 32'h0);
        idle(4, 1);

        // R8: result clears at start of a long run
        wr(0, (32'd1 << 24) | 32'd5000);
        wr(1, 32'h100);
        idle(6, 2);
        chk(reg_rdata == 0, "R8 result zero after start", reg_rdata, 0);
        wr(1, 32'h0);
        idle(4, 1);

        // R5: window of zero
        wr(0, (32'd1 << 24));
        wr(1, 32'h100);
        poll(50);
        read_result(tmp);
        chk(tmp == 1, "R5 zero window result", tmp, 1);
        wr(0, 32'd0);
        idle(4, 1);

        // R9: saturation, 1200 edges of 37 ns exceeds the counter
        meas_half = 18.5;
        idle(10, 1);
        wr(0, (32'd1 << 24) | 32'd1200);
        poll(8000);
        read_result(tmp);
        chk(tmp == 0, "R9 saturated run reports zero", tmp, 0);
        idle(5, 1);
        wr(0, 32'd1200);
        idle(4, 1);

        // normal run after saturation
        wr(0, (32'd1 << 24) | 32'd30);
        poll(3000);
        read_result(tmp);
        chk(tmp == k_seen - 1 && tmp > 0, "R4 run after saturation", tmp, k_seen - 1);
        wr(0, 32'd0);
        wr(1, 32'h0);
        idle(4, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule